// File: doc/BRIEF.md
# Windowed watchdog timer

This block is a system supervision timer. A 12-bit down-counter decrements once for every pulse on a tick-enable input. Software must restart it through a control register before it runs out. A restart counts only while the counter sits inside an allowed window, at or below a programmable delta value. A restart that comes while the counter is still above that value is an error. An underflow and an early restart are both faults.

A fault sets a sticky status flag. It can raise a level interrupt, and it can request a one-cycle reset. The reset request goes either to the processor only or to the whole system. The configuration word can be written once after reset. That single write also reloads the counter. The counter can be told to pause while the processor is in debug state or while the system is idle. A disable bit freezes the whole timer.

Top module: `winwdog_top`

## Requirements
- R1: After reset all outputs are low. The status word reads 0x0FFF0000, with the count in bits 27:16, the underflow flag in bit 0 and the error flag in bit 1. The mode word at address 1 reads 0x0FFF2FFF, which is reload 0xFFF, delta 0xFFF and reset-enable set.
- R2: The mode word at address 1 has this layout: reload value in bits 11:0, interrupt enable in bit 12, reset enable in bit 13, processor-only select in bit 14, disable in bit 15, delta in bits 27:16, debug pause in bit 28, idle pause in bit 29. Only the first write after reset is taken, and that write reloads the count with its new reload value. Later writes leave the mode word unchanged.
- R3: Each cycle with tick high and the timer running lowers the count by one. A tick at count 0 is an underflow. It reloads the reload value and sets status bit 0.
- R4: A restart is a write to address 0 with bit 0 set. When the count is at or below the delta, a restart reloads the reload value with no fault.
- R5: A restart while the count is above the delta is an error fault. It sets status bit 1 and reloads the reload value.
- R6: The interrupt is high while the interrupt enable is set and either status flag is set. A read of the status word at address 2 clears both flags.
- R7: A fault with reset enable set gives a one-cycle pulse in the cycle after the fault. The pulse goes on cpu_rst_req when processor-only select is 1 and on sys_rst_req when it is 0. With reset enable clear, neither output pulses.
- R8: With debug pause set, ticks are ignored while dbg_state is high. With debug pause clear, dbg_state has no effect.
- R9: With idle pause set, ticks are ignored while idle_state is high. With idle pause clear, idle_state has no effect.
- R10: With disable set, the count is frozen, restarts are ignored and no fault occurs.
- R11: When a restart and a tick arrive in the same cycle, the restart wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading status clears flags) |
| addr | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register |
| tick | input | 1 | Count-enable pulse |
| dbg_state | input | 1 | Processor is in debug state |
| idle_state | input | 1 | System is idle |
| irq | output | 1 | Fault interrupt (level) |
| cpu_rst_req | output | 1 | Processor-only reset request pulse |
| sys_rst_req | output | 1 | Full-system reset request pulse |

## Verification
The bench builds the block with its package defaults: a 12-bit counter and a reload value of 0xFFF out of reset. With these values a full-range countdown from 0xFFF to 0 takes only a few thousand ticks. That makes the window edge at count equal to the delta reachable in exact boundary vectors. Small reload values such as 0 and 3 bring underflow within a handful of ticks. Those cases drive the fault routing, the interrupt and the pulse timing.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 2 * CNT_W + 6;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic             idle_pause;
        logic             dbg_pause;
        logic [CNT_W-1:0] delta;
        logic             disable_wd;
        logic             cpu_only;
        logic             rst_en;
        logic             irq_en;
        logic [CNT_W-1:0] reload;
    } mode_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_UNDER = 2'd1,
        FLT_EARLY = 2'd2
    } fault_e;

    localparam mode_t MODE_DEFAULT = '{
        idle_pause: 1'b0, dbg_pause: 1'b0, delta: '1, disable_wd: 1'b0,
        cpu_only: 1'b0, rst_en: 1'b1, irq_en: 1'b0, reload: '1
    };

    function automatic mode_t word_to_mode(input logic [DATA_W-1:0] w);
        return mode_t'(w[MODE_W-1:0]);
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        return {{(DATA_W-MODE_W){1'b0}}, m};
    endfunction

    function automatic logic [DATA_W-1:0] status_word(
        input logic [CNT_W-1:0] cnt, input logic under, input logic early);
        logic [DATA_W-1:0] w;
        w = '0;
        w[16 +: CNT_W] = cnt;
        w[1] = early;
        w[0] = under;
        return w;
    endfunction

endpackage

// File: rtl/winwdog_cfg.sv
module winwdog_cfg
    import winwdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode_o,
    output logic              locked_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);
    mode_t mode_q;
    logic  locked_q;
    mode_t mode_new;

    always_comb begin
        mode_new   = word_to_mode(wdata);
        load_o     = wr_mode && !locked_q;
        load_val_o = mode_new.reload;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_DEFAULT;
            locked_q <= 1'b0;
        end else if (load_o) begin
            mode_q   <= mode_new;
            locked_q <= 1'b1;
        end
    end

    assign mode_o   = mode_q;
    assign locked_o = locked_q;
endmodule

// File: rtl/winwdog_cnt.sv
module winwdog_cnt
    import winwdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    input  logic             tick,
    input  logic             dbg_state,
    input  logic             idle_state,
    output logic [CNT_W-1:0] cnt_o,
    output fault_e           fault_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             running;
    logic             rs_ok;
    logic             tk_ok;

    always_comb begin
        running = !mode.disable_wd
                  && !(mode.dbg_pause && dbg_state)
                  && !(mode.idle_pause && idle_state);
        rs_ok   = restart && !mode.disable_wd;
        tk_ok   = tick && running;
        fault_o = FLT_NONE;
        if (!load) begin
            if (rs_ok) begin
                if (cnt_q > mode.delta) fault_o = FLT_EARLY;
            end else if (tk_ok && cnt_q == '0) begin
                fault_o = FLT_UNDER;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= MODE_DEFAULT.reload;
        else if (load)
            cnt_q <= load_val;
        else if (rs_ok)
            cnt_q <= mode.reload;
        else if (tk_ok)
            cnt_q <= (cnt_q == '0) ? mode.reload : cnt_q - 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/winwdog_flt.sv
module winwdog_flt
    import winwdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  mode_t  mode,
    input  fault_e fault,
    input  logic   stat_clr,
    output logic   under_o,
    output logic   early_o,
    output logic   irq_o,
    output logic   cpu_rst_o,
    output logic   sys_rst_o
);
    logic under_q, early_q, cpu_q, sys_q;
    logic any_fault;

    assign any_fault = (fault != FLT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            under_q <= 1'b0;
            early_q <= 1'b0;
            cpu_q   <= 1'b0;
            sys_q   <= 1'b0;
        end else begin
            under_q <= (under_q && !stat_clr) || (fault == FLT_UNDER);
            early_q <= (early_q && !stat_clr) || (fault == FLT_EARLY);
            cpu_q   <= any_fault && mode.rst_en && mode.cpu_only;
            sys_q   <= any_fault && mode.rst_en && !mode.cpu_only;
        end
    end

    assign under_o   = under_q;
    assign early_o   = early_q;
    assign irq_o     = mode.irq_en && (under_q || early_q);
    assign cpu_rst_o = cpu_q;
    assign sys_rst_o = sys_q;
endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
    import winwdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    input  logic              dbg_state,
    input  logic              idle_state,
    output logic              irq,
    output logic              cpu_rst_req,
    output logic              sys_rst_req
);
    mode_t            mode;
    logic             locked;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    fault_e           fault;
    logic             under_f, early_f;
    logic             wr_mode, restart, stat_clr;

    assign wr_mode  = wr_en && (addr == ADDR_MODE);
    assign restart  = wr_en && (addr == ADDR_CTRL) && wdata[0];
    assign stat_clr = rd_en && (addr == ADDR_STAT);

    winwdog_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .wdata(wdata),
        .mode_o(mode), .locked_o(locked), .load_o(load), .load_val_o(load_val)
    );

    winwdog_cnt u_cnt (
        .clk(clk), .rst(rst), .mode(mode), .load(load), .load_val(load_val),
        .restart(restart), .tick(tick), .dbg_state(dbg_state),
        .idle_state(idle_state), .cnt_o(cnt), .fault_o(fault)
    );

    winwdog_flt u_flt (
        .clk(clk), .rst(rst), .mode(mode), .fault(fault), .stat_clr(stat_clr),
        .under_o(under_f), .early_o(early_f), .irq_o(irq),
        .cpu_rst_o(cpu_rst_req), .sys_rst_o(sys_rst_req)
    );

    always_comb begin
        unique case (addr)
            ADDR_MODE: rdata = mode_to_word(mode);
            ADDR_STAT: rdata = status_word(cnt, under_f, early_f);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/winwdog_chk.sv
module winwdog_chk
    import winwdog_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input mode_t            mode,
    input logic             locked,
    input logic             wr_en,
    input logic [CNT_W-1:0] cnt,
    input logic             tick,
    input logic             dbg_state,
    input logic             idle_state,
    input logic             under_f,
    input logic             early_f,
    input logic             cpu_rst_req,
    input logic             sys_rst_req
);
    // R2
    mode_once_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(mode));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= mode.reload);

    // R7
    rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rst_req && sys_rst_req));

    // R7
    cpu_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rst_req |=> !cpu_rst_req);

    // R7
    sys_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req);

    // R7
    rst_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst_req || sys_rst_req) |-> (under_f || early_f));

    // R8
    dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && tick && dbg_state && mode.dbg_pause && !wr_en) |=> $stable(cnt));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && tick && idle_state && mode.idle_pause && !wr_en) |=> $stable(cnt));

    // R10
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && mode.disable_wd) |=> $stable(cnt));
endmodule

bind winwdog_top winwdog_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode), .locked(locked), .wr_en(wr_en),
    .cnt(cnt), .tick(tick), .dbg_state(dbg_state), .idle_state(idle_state),
    .under_f(under_f), .early_f(early_f),
    .cpu_rst_req(cpu_rst_req), .sys_rst_req(sys_rst_req)
);

// File: tb/winwdog_tb_top.sv
module winwdog_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0, dbg_state = 1'b0, idle_state = 1'b0;
    logic        irq, cpu_rst_req, sys_rst_req;
    int          n_vec = 0, n_bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    winwdog_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .dbg_state(dbg_state),
        .idle_state(idle_state), .irq(irq), .cpu_rst_req(cpu_rst_req),
        .sys_rst_req(sys_rst_req)
    );

    // {reload, delta, ticks before restart}
    localparam logic [35:0] VEC [6] = '{
        {12'd100, 12'd50, 12'd60},
        {12'd100, 12'd50, 12'd49},
        {12'd100, 12'd50, 12'd50},
        {12'd20,  12'd20, 12'd0},
        {12'hFFF, 12'd0,  12'hFFF},
        {12'd30,  12'd10, 12'd19}
    };

    function automatic logic [31:0] mk(input logic [11:0] rl, input logic [11:0] dl,
        input logic ie, input logic re, input logic co, input logic ds,
        input logic dp, input logic ip);
        return {2'b00, ip, dp, dl, ds, co, re, ie, rl};
    endfunction

    function automatic logic [31:0] st(input logic [11:0] c, input logic e, input logic u);
        return {4'h0, c, 14'h0, e, u};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; tick = 0; dbg_state = 0; idle_state = 0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(2'd2, rv); chk("R1 status", rv, 32'h0FFF0000);
        rd(2'd1, rv); chk("R1 mode", rv, 32'h0FFF2FFF);
        chk("R1 outputs", {29'd0, irq, cpu_rst_req, sys_rst_req}, 32'd0);

        // table walk: R2 reload on write, R3 countdown, R4/R5 window
        for (int i = 0; i < 6; i++) begin
            logic [11:0] rl, dl, nt, left;
            {rl, dl, nt} = VEC[i];
            left = rl - nt;
            do_reset();
            wr(2'd1, mk(rl, dl, 0, 0, 0, 0, 0, 0));
            rd(2'd2, rv); chk("R2 load", rv, st(rl, 0, 0));
            ticks(int'(nt));
            rd(2'd2, rv); chk("R3 count", rv, st(left, 0, 0));
            wr(2'd0, 32'd1);
            rd(2'd2, rv);
            chk((left > dl) ? "R5 early restart" : "R4 restart", rv, st(rl, left > dl, 0));
        end

        // R2 second mode write ignored (last table entry holds)
        wr(2'd1, mk(12'd7, 12'd7, 1, 1, 1, 1, 1, 1));
        rd(2'd1, rv); chk("R2 write once", rv, mk(12'd30, 12'd10, 0, 0, 0, 0, 0, 0));

        // R3 underflow, R6 irq, R7 processor-only pulse
        do_reset();
        wr(2'd1, mk(12'd3, 12'hFFF, 1, 1, 1, 0, 0, 0));
        ticks(4);
        chk("R7 cpu pulse", {30'd0, cpu_rst_req, sys_rst_req}, 32'd2);
        chk("R6 irq set", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R7 pulse ends", {30'd0, cpu_rst_req, sys_rst_req}, 32'd0);
        rd(2'd2, rv); chk("R3 underflow", rv, st(12'd3, 0, 1));
        chk("R6 irq cleared", {31'd0, irq}, 32'd0);

        // R5 early restart, R7 system reset, R6 irq disabled
        do_reset();
        wr(2'd1, mk(12'd10, 12'd2, 0, 1, 0, 0, 0, 0));
        wr(2'd0, 32'd1);
        chk("R7 sys pulse", {30'd0, cpu_rst_req, sys_rst_req}, 32'd1);
        chk("R6 irq masked", {31'd0, irq}, 32'd0);

        // R7 reset disabled
        do_reset();
        wr(2'd1, mk(12'd0, 12'hFFF, 1, 0, 0, 0, 0, 0));
        ticks(1);
        chk("R7 no reset", {29'd0, irq, cpu_rst_req, sys_rst_req}, 32'd4);

        // R8 debug pause, R9 idle has no effect when its bit is clear
        do_reset();
        wr(2'd1, mk(12'd50, 12'hFFF, 0, 0, 0, 0, 1, 0));
        dbg_state = 1'b1; ticks(5); dbg_state = 1'b0;
        rd(2'd2, rv); chk("R8 dbg paused", rv, st(12'd50, 0, 0));
        idle_state = 1'b1; ticks(5); idle_state = 1'b0;
        rd(2'd2, rv); chk("R9 idle ignored", rv, st(12'd45, 0, 0));

        // R9 idle pause, R8 debug ignored when its bit is clear
        do_reset();
        wr(2'd1, mk(12'd50, 12'hFFF, 0, 0, 0, 0, 0, 1));
        idle_state = 1'b1; ticks(5); idle_state = 1'b0;
        rd(2'd2, rv); chk("R9 idle paused", rv, st(12'd50, 0, 0));
        dbg_state = 1'b1; ticks(5); dbg_state = 1'b0;
        rd(2'd2, rv); chk("R8 dbg ignored", rv, st(12'd45, 0, 0));

        // R10 disabled
        do_reset();
        wr(2'd1, mk(12'd40, 12'd5, 1, 1, 0, 1, 0, 0));
        ticks(10);
        wr(2'd0, 32'd1);
        chk("R10 no pulse", {29'd0, irq, cpu_rst_req, sys_rst_req}, 32'd0);
        rd(2'd2, rv); chk("R10 frozen", rv, st(12'd40, 0, 0));

        // R11 restart beats tick
        do_reset();
        wr(2'd1, mk(12'd20, 12'd20, 0, 0, 0, 0, 0, 0));
        tick = 1'b1;
        wr(2'd0, 32'd1);
        tick = 1'b0;
        rd(2'd2, rv); chk("R11 restart wins", rv, st(12'd20, 0, 0));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule